// File: doc/BRIEF.md
# Instruction Word Classifier and Field Decoder

This block takes one 16-bit instruction word of an octal-structured minicomputer instruction set, together with the address the word was fetched from. One clock later it reports which of seven format families the word belongs to. It also reports a mnemonic index and every operand field the family carries, already split out. Branch words get a sign-extended offset and a computed target. Trap words get their low byte as a trap code. Every word gets the number of extension words its operand specifiers will pull from the stream after the opcode.

A disassembly walker or a front-end prefetcher feeds words in with a strobe and uses the extension-word count to step over the words that follow. Words fetched from the low interrupt-vector region are marked as data and are not decoded. Operand fetch, execution and flags are left to other logic.

Top module: `opcode_sorter`

## Requirements
- R1: Outputs are registered. `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. Reset (active-low `rst_n`) clears `out_valid`.
- R2: When `in_addr` is below octal 000100, `out_vector` is 1, `out_class` is 0, `out_op` is 63 and all field outputs and `out_ext` are 0. At address 000100 and above, `out_vector` is 0 and the word is decoded.
- R3: Zero-operand words (class 1) match on the whole word. 000000..000006 give indices 0..6. 000240 gives 7. 000241, 000242, 000244, 000250, 000257 give 8..12. 000261, 000262, 000264, 000270, 000277 give 13..17. Other codes between 000241 and 000277 are unrecognised.
- R4: Words 104000..104377 give class 6, index 18. Words 104400..104777 give class 6, index 19. `out_code` carries the low byte. Trap decoding takes priority over every family except zero-operand.
- R5: Words 000400..001777 are branches (class 5). A high byte of 1, 2 or 3 gives index 20, 21 or 22. `out_offset` is the low byte sign-extended to 16 bits. `out_target` is `in_addr` + 2 + 2*offset, modulo 2^16.
- R6: 00020R gives class 7, index 23. 07500R gives class 7, index 24. `out_reg` is R, the low 3 bits.
- R7: 004RDD gives class 4, index 25. 070RDD gives class 4, index 26. `out_reg` is bits 8:6. The destination mode is bits 5:3 and the destination register is bits 2:0.
- R8: Single-operand words 0001DD, 0050DD and 0052DD give class 2 with indices 27, 28 and 29. The destination is taken from bits 5:0.
- R9: Double-operand words 01SSDD and 02SSDD give class 3 with indices 30 and 31. The source mode is bits 11:9, the source register bits 8:6, the destination mode bits 5:3 and the destination register bits 2:0.
- R10: `out_ext` counts the specifiers the family uses (destination for classes 2 and 4; source and destination for class 3) whose mode is 6 or 7, or whose mode is 2 or 3 with register 7. Classes without specifiers report 0.
- R11: A word matching none of the families gives class 0 and index 63, with all fields and `out_ext` 0. Fields not used by a family are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 16 | Instruction word |
| in_addr | input | 16 | Byte address of the word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_class | output | 3 | Family: 0 none, 1 zero-op, 2 single, 3 double, 4 reg+operand, 5 branch, 6 trap, 7 reg-only |
| out_op | output | 6 | Mnemonic index, 63 when unrecognised |
| out_src_mode | output | 3 | Source addressing mode |
| out_src_reg | output | 3 | Source register |
| out_dst_mode | output | 3 | Destination addressing mode |
| out_dst_reg | output | 3 | Destination register |
| out_reg | output | 3 | Register argument |
| out_offset | output | 16 | Sign-extended branch offset |
| out_target | output | 16 | Branch target address |
| out_code | output | 8 | Trap code |
| out_ext | output | 2 | Extension words needed |
| out_vector | output | 1 | Word lies in the vector region |

## Verification
The bench sweeps every addressing-mode and register combination on both operands of a move, so that a decoder counting register 7 under the wrong modes, or ignoring the deferred index mode, reports a wrong extension count. It probes the edges of each range: 104377/104400 between the two trap kinds, 104777/105000 at the end of the trap range, 000377/000400 and 001777/002000 around the branches, 075007/075010, and the in-between codes 000243 and 000276. A decoder with a loose mask there would accept a word it should reject. Branch offsets of 0x7F and 0x80 catch a missing sign extension. Addresses 000076 and 000100 catch an off-by-one in the vector test. Random words from each family, mixed with fully random words, are compared against a bench model.

// File: rtl/opcode_sorter.sv
module opcode_sorter #(
  parameter logic [15:0] VEC_LIMIT = 16'o000100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  input  logic [15:0] in_addr,
  output logic        out_valid,
  output logic [2:0]  out_class,
  output logic [5:0]  out_op,
  output logic [2:0]  out_src_mode,
  output logic [2:0]  out_src_reg,
  output logic [2:0]  out_dst_mode,
  output logic [2:0]  out_dst_reg,
  output logic [2:0]  out_reg,
  output logic [15:0] out_offset,
  output logic [15:0] out_target,
  output logic [7:0]  out_code,
  output logic [1:0]  out_ext,
  output logic        out_vector
);
  localparam logic [2:0] C_NONE = 3'd0, C_ZERO = 3'd1, C_SINGLE = 3'd2, C_DOUBLE = 3'd3,
                         C_REGOP = 3'd4, C_BRANCH = 3'd5, C_TRAP = 3'd6, C_REGONLY = 3'd7;
  localparam logic [5:0] OP_NONE = 6'd63;

  function automatic logic [1:0] ext_of(input logic [5:0] spec);
    return (spec[5:4] == 2'b11 || (spec[5:4] == 2'b01 && spec[2:0] == 3'd7)) ? 2'd1 : 2'd0;
  endfunction

  logic [2:0]  c_class;
  logic [5:0]  c_op;
  logic [5:0]  c_src, c_dst;
  logic [2:0]  c_reg;
  logic [15:0] c_off, c_tgt;
  logic [7:0]  c_code;
  logic        c_vec, use_src, use_dst;

  assign c_vec = in_addr < VEC_LIMIT;

  always_comb begin
    c_class = C_NONE;
    c_op    = OP_NONE;
    c_src   = '0;
    c_dst   = '0;
    c_reg   = '0;
    c_off   = '0;
    c_tgt   = '0;
    c_code  = '0;
    use_src = 1'b0;
    use_dst = 1'b0;
    if (!c_vec) begin
      c_class = C_ZERO;
      unique case (in_word)
        16'o000000: c_op = 6'd0;
        16'o000001: c_op = 6'd1;
        16'o000002: c_op = 6'd2;
        16'o000003: c_op = 6'd3;
        16'o000004: c_op = 6'd4;
        16'o000005: c_op = 6'd5;
        16'o000006: c_op = 6'd6;
        16'o000240: c_op = 6'd7;
        16'o000241: c_op = 6'd8;
        16'o000242: c_op = 6'd9;
        16'o000244: c_op = 6'd10;
        16'o000250: c_op = 6'd11;
        16'o000257: c_op = 6'd12;
        16'o000261: c_op = 6'd13;
        16'o000262: c_op = 6'd14;
        16'o000264: c_op = 6'd15;
        16'o000270: c_op = 6'd16;
        16'o000277: c_op = 6'd17;
        default:    c_class = C_NONE;
      endcase
      if (c_class == C_NONE) begin
        if (in_word[15:9] == 7'o104) begin
          c_class = C_TRAP;
          c_op    = in_word[8] ? 6'd19 : 6'd18;
          c_code  = in_word[7:0];
        end else if (in_word[15:10] == 6'd0 && in_word[9:8] != 2'd0) begin
          c_class = C_BRANCH;
          c_op    = 6'd19 + {4'd0, in_word[9:8]};
          c_off   = {{8{in_word[7]}}, in_word[7:0]};
          c_tgt   = in_addr + 16'd2 + {c_off[14:0], 1'b0};
        end else if (in_word[15:3] == 13'o00020 || in_word[15:3] == 13'o07500) begin
          c_class = C_REGONLY;
          c_op    = in_word[14] ? 6'd24 : 6'd23;
          c_reg   = in_word[2:0];
        end else if (in_word[15:9] == 7'o004 || in_word[15:9] == 7'o070) begin
          c_class = C_REGOP;
          c_op    = in_word[13] ? 6'd26 : 6'd25;
          c_reg   = in_word[8:6];
          c_dst   = in_word[5:0];
          use_dst = 1'b1;
        end else if (in_word[15:6] == 10'o0001 || in_word[15:6] == 10'o0050 ||
                     in_word[15:6] == 10'o0052) begin
          c_class = C_SINGLE;
          c_op    = (in_word[15:6] == 10'o0001) ? 6'd27 : (in_word[7] ? 6'd29 : 6'd28);
          c_dst   = in_word[5:0];
          use_dst = 1'b1;
        end else if (in_word[15:12] == 4'd1 || in_word[15:12] == 4'd2) begin
          c_class = C_DOUBLE;
          c_op    = in_word[13] ? 6'd31 : 6'd30;
          c_src   = in_word[11:6];
          c_dst   = in_word[5:0];
          use_src = 1'b1;
          use_dst = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= C_NONE;
      out_op    <= OP_NONE;
      {out_src_mode, out_src_reg, out_dst_mode, out_dst_reg} <= '0;
      out_reg    <= '0;
      out_offset <= '0;
      out_target <= '0;
      out_code   <= '0;
      out_ext    <= '0;
      out_vector <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_class <= c_class;
        out_op    <= c_op;
        {out_src_mode, out_src_reg} <= c_src;
        {out_dst_mode, out_dst_reg} <= c_dst;
        out_reg    <= c_reg;
        out_offset <= c_off;
        out_target <= c_tgt;
        out_code   <= c_code;
        out_ext    <= (use_src ? ext_of(c_src) : 2'd0) + (use_dst ? ext_of(c_dst) : 2'd0);
        out_vector <= c_vec;
      end
    end
  end
endmodule

// File: rtl/opcode_sorter_chk.sv
module opcode_sorter_chk #(
  parameter logic [15:0] VEC_LIMIT = 16'o000100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_word,
  input logic [15:0] in_addr,
  input logic        out_valid,
  input logic [2:0]  out_class,
  input logic [5:0]  out_op,
  input logic [2:0]  out_src_mode,
  input logic [2:0]  out_src_reg,
  input logic [2:0]  out_dst_mode,
  input logic [2:0]  out_dst_reg,
  input logic [2:0]  out_reg,
  input logic [15:0] out_offset,
  input logic [15:0] out_target,
  input logic [7:0]  out_code,
  input logic [1:0]  out_ext,
  input logic        out_vector
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_vector_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr < VEC_LIMIT) |=> (out_vector && out_class == 3'd0 && out_ext == 2'd0));
  a_r3_halt_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == 16'd0 && in_addr >= VEC_LIMIT) |=> (out_class == 3'd1 && out_op == 6'd0));
  a_r4_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[15:9] == 7'o104 && in_addr >= VEC_LIMIT) |=> (out_class == 3'd6 && out_code == $past(in_word[7:0])));
  a_r10_no_ext_without_specifiers: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_class == 3'd1 || out_class == 3'd5 || out_class == 3'd6 || out_class == 3'd7)) |-> out_ext == 2'd0);
endmodule

bind opcode_sorter opcode_sorter_chk #(.VEC_LIMIT(VEC_LIMIT)) u_chk (.*);

// File: tb/test_opcode_sorter.sv
`timescale 1ns/1ps
module test_opcode_sorter;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] in_word = '0, in_addr = '0;
  logic out_valid, out_vector;
  logic [2:0] out_class, out_src_mode, out_src_reg, out_dst_mode, out_dst_reg, out_reg;
  logic [5:0] out_op;
  logic [15:0] out_offset, out_target;
  logic [7:0] out_code;
  logic [1:0] out_ext;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opcode_sorter i_opcode_sorter (.*);

  function automatic int ext1(input logic [5:0] s);
    int m = int'(s[5:3]);
    int r = int'(s[2:0]);
    return (m >= 6 || (r == 7 && (m == 2 || m == 3))) ? 1 : 0;
  endfunction

  localparam logic [15:0] ZCODES [18] = '{16'o0, 16'o1, 16'o2, 16'o3, 16'o4, 16'o5, 16'o6,
    16'o240, 16'o241, 16'o242, 16'o244, 16'o250, 16'o257, 16'o261, 16'o262, 16'o264, 16'o270, 16'o277};

  // packed: class op sm sr dm dr reg off tgt code ext vec
  function automatic logic [66:0] model(input logic [15:0] w, input logic [15:0] a);
    logic [2:0] cls = 0, rn = 0;
    logic [5:0] op = 63, s = 0, d = 0;
    logic [15:0] off = 0, tgt = 0;
    logic [7:0] tc = 0;
    int ex = 0;
    logic vec = a < 16'o100;
    if (!vec) begin
      for (int k = 0; k < 18; k++) if (w == ZCODES[k]) begin cls = 1; op = 6'(k); end
      if (cls == 0) begin
        if (w >= 16'o104000 && w <= 16'o104777) begin
          cls = 6; op = (w < 16'o104400) ? 18 : 19; tc = w[7:0];
        end else if (w >= 16'o000400 && w <= 16'o001777) begin
          cls = 5; op = 6'(19 + (w >> 8)); off = {{8{w[7]}}, w[7:0]}; tgt = a + 16'd2 + off * 16'd2;
        end else if ((w & 16'o177770) == 16'o000200 || (w & 16'o177770) == 16'o075000) begin
          cls = 7; op = (w < 16'o1000) ? 23 : 24; rn = w[2:0];
        end else if ((w & 16'o177000) == 16'o004000 || (w & 16'o177000) == 16'o070000) begin
          cls = 4; op = (w < 16'o010000) ? 25 : 26; rn = w[8:6]; d = w[5:0]; ex = ext1(d);
        end else if ((w & 16'o177700) == 16'o000100) begin
          cls = 2; op = 27; d = w[5:0]; ex = ext1(d);
        end else if ((w & 16'o177700) == 16'o005000) begin
          cls = 2; op = 28; d = w[5:0]; ex = ext1(d);
        end else if ((w & 16'o177700) == 16'o005200) begin
          cls = 2; op = 29; d = w[5:0]; ex = ext1(d);
        end else if ((w & 16'o170000) == 16'o010000 || (w & 16'o170000) == 16'o020000) begin
          cls = 3; op = (w < 16'o020000) ? 30 : 31; s = w[11:6]; d = w[5:0]; ex = ext1(s) + ext1(d);
        end
      end
    end
    return {cls, op, s, d, rn, off, tgt, tc, 2'(ex), vec};
  endfunction

  function automatic string tag(input logic [66:0] e);
    if (e[0]) return "R2";
    case (e[66:64])
      3'd1: return "R3";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R7";
      3'd5: return "R5";
      3'd6: return "R4";
      3'd7: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [15:0] w, input logic [15:0] a);
    logic [66:0] got, exp;
    in_word = w; in_addr = a; in_valid = 1'b1;
    @(negedge clk);
    exp = model(w, a);
    got = {out_class, out_op, out_src_mode, out_src_reg, out_dst_mode, out_dst_reg, out_reg,
           out_offset, out_target, out_code, out_ext, out_vector};
    checks++;
    if (!out_valid || got !== exp) begin
      fails++;
      $display("FAIL %s word=%o addr=%o valid=%b got=%h exp=%h (R10 ext got=%0d exp=%0d)",
               tag(exp), w, a, out_valid, got, exp, out_ext, exp[2:1]);
    end
  endtask

  task automatic idle_check;
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid got=%b exp=0", out_valid);
    end
  endtask

  function automatic logic [15:0] rand_word;
    logic [15:0] r = 16'($urandom);
    case ($urandom % 9)
      0: return ZCODES[$urandom % 18];
      1: return 16'o104000 | (r & 16'o777);
      2: return 16'o000400 + (r % 16'o1400);
      3: return ($urandom % 2) ? (16'o000200 | (r & 7)) : (16'o075000 | (r & 7));
      4: return (($urandom % 2) ? 16'o004000 : 16'o070000) | (r & 16'o777);
      5: return (($urandom % 3) == 0 ? 16'o000100 : (($urandom % 2) ? 16'o005000 : 16'o005200)) | (r & 16'o77);
      6: return (($urandom % 2) ? 16'o010000 : 16'o020000) | (r & 16'o7777);
      default: return r;
    endcase
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    @(negedge clk);
    checks++; // R1 reset state
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 reset out_valid got=%b exp=0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 18; k++) apply(ZCODES[k], 16'o1000); // R3
    apply(16'o000243, 16'o1000); apply(16'o000276, 16'o1000); apply(16'o000007, 16'o1000); // R3/R11
    apply(16'o104000, 16'o2000); apply(16'o104377, 16'o2000); // R4
    apply(16'o104400, 16'o2000); apply(16'o104777, 16'o2000); apply(16'o105000, 16'o2000);
    apply(16'o000377, 16'o2000); apply(16'o000400, 16'o2000); apply(16'o000577, 16'o2000); // R5
    apply(16'o000600, 16'o2000); apply(16'o001377, 16'o0200); apply(16'o001777, 16'o0100);
    apply(16'o002000, 16'o2000);
    apply(16'o000200, 16'o2000); apply(16'o000207, 16'o2000); apply(16'o075007, 16'o2000); // R6
    apply(16'o075010, 16'o2000);
    apply(16'o004767, 16'o2000); apply(16'o070127, 16'o2000); // R7
    apply(16'o000137, 16'o2000); apply(16'o005067, 16'o2000); apply(16'o005227, 16'o2000); // R8
    apply(16'o000000, 16'o000076); apply(16'o012767, 16'o000000); apply(16'o012767, 16'o000100); // R2
    idle_check(); idle_check(); // R1
    for (int m = 0; m < 64; m++) apply(16'o010000 | 16'(m << 6) | 16'(63 - m), 16'o3000); // R9 R10
    for (int n = 0; n < 3000; n++) begin
      apply(rand_word(), ($urandom % 16 == 0) ? 16'($urandom % 64) : (16'($urandom) | 16'o100));
      if (n % 97 == 0) idle_check();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule